// File: doc/BRIEF.md
# Timer Channel Output Control

This block forms the output levels of a multi-channel timer unit. Each channel has an output latch, and that latch drives the channel's output pin. The latch moves in response to single-cycle event pulses from the channel counters. Its behaviour is set by four per-channel settings: an output mode, a polarity, an output enable and a master selection.

In single mode, a channel's own event inverts its latch. In paired mode, a slave channel combines two events. The event of its selected master sets the latch and its own event resets it, or the reverse when the polarity bit is 1. This produces PWM-style waveforms. When both events arrive in the same cycle, the reset wins, so a 0% duty output stays low.

Software loads the latch directly, but only while the channel's output is disabled. Timer events are accepted only while the output is enabled. The latch value is always visible on the level output.

Top module: `tmr_out_ctl`

## Requirements
- R1: In single mode (mode bit 0) with output enabled, a channel's own event inverts its latch at the next clock edge, and the polarity bit has no effect.
- R2: In paired mode (mode bit 1) with polarity 0 and output enabled, the selected master's event sets the latch to 1 and the channel's own event clears it to 0.
- R3: In paired mode with polarity 1, the roles swap: the master's event clears the latch and the channel's own event sets it.
- R4: When the set event and the reset event of a paired channel arrive in the same cycle, the latch ends at 0.
- R5: While a channel's enable bit is 1, a software write to its latch bit leaves the latch unchanged.
- R6: While a channel's enable bit is 0, its events leave the latch unchanged, and a software latch write loads the written bit.
- R7: Only even channels act as masters, and only for higher-numbered channels: channel 0 for channels 1, 2 and 3, and channel 2 for channel 3. Any other master selection gives no master event.
- R8: The write port selects a register with `wr_sel`: 0 = mode, 1 = polarity, 2 = enable, 3 = latch, 4 = master select. Bit n of `wr_mask` enables the write of channel n. Channel n uses data bit n, except for master select, where it uses bits [2n+1:2n].
- R9: After reset, all latches, modes, polarities, enables and master selections are 0, and `lvl_o` always shows the current latch bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | NUM_CH | Per-channel single-cycle timer event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R8) |
| wr_data | input | NUM_CH*SEL_W | Write data |
| wr_mask | input | NUM_CH | Per-channel write mask |
| lvl_o | output | NUM_CH | Output latch bits, equal to the pin levels |

## Verification
The bench uses the default build: four channels, a 2-bit master selection field and a master mask of channels 0 and 2. This is the smallest width at which every allowed pairing exists at once, and it also leaves invalid encodings to select. These are an odd channel and a master above its slave. With those values the bench drives channel 0 as a master for two slaves while channel 2 masters channel 3 in the same event. It also covers coincident set and reset under both polarities, and masked writes that cross the enable boundary.

// File: rtl/tmr_out_pkg.sv
package tmr_out_pkg;
   typedef enum logic [2:0] {
      SEL_MODE = 3'd0,
      SEL_POL  = 3'd1,
      SEL_EN   = 3'd2,
      SEL_LVL  = 3'd3,
      SEL_MSEL = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/tmr_out_regs.sv
module tmr_out_regs
   import tmr_out_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SEL_W  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [2:0]                   wr_sel,
   input  logic [NUM_CH*SEL_W-1:0]      wr_data,
   input  logic [NUM_CH-1:0]            wr_mask,
   output logic [NUM_CH-1:0]            mode_q,
   output logic [NUM_CH-1:0]            pol_q,
   output logic [NUM_CH-1:0]            en_q,
   output logic [NUM_CH-1:0][SEL_W-1:0] msel_q,
   output logic [NUM_CH-1:0]            lvl_wr
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(wr_sel);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[n] <= 1'b0;
            pol_q[n]  <= 1'b0;
            en_q[n]   <= 1'b0;
            msel_q[n] <= '0;
         end else if (wr_en && wr_mask[n]) begin
            case (sel)
               SEL_MODE: mode_q[n] <= wr_data[n];
               SEL_POL:  pol_q[n]  <= wr_data[n];
               SEL_EN:   en_q[n]   <= wr_data[n];
               SEL_MSEL: msel_q[n] <= wr_data[n*SEL_W +: SEL_W];
               default:  ;
            endcase
         end
      end
      assign lvl_wr[n] = wr_en && wr_mask[n] && (sel == SEL_LVL);
   end
endmodule

// File: rtl/tmr_out_route.sv
module tmr_out_route #(
   parameter int          NUM_CH      = 4,
   parameter int          SEL_W       = 2,
   parameter logic [31:0] MASTER_MASK = 32'h5
) (
   input  logic [NUM_CH-1:0]            ev_i,
   input  logic [NUM_CH-1:0][SEL_W-1:0] msel_q,
   output logic [NUM_CH-1:0]            mst_ev
);
   for (genvar s = 0; s < NUM_CH; s++) begin : g_slave
      always_comb begin
         mst_ev[s] = 1'b0;
         for (int m = 0; m < s; m++) begin
            if (MASTER_MASK[m] && (int'(msel_q[s]) == m))
               mst_ev[s] = ev_i[m];
         end
      end
   end
endmodule

// File: rtl/tmr_out_cell.sv
module tmr_out_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic mode,
   input  logic pol,
   input  logic own_ev,
   input  logic mst_ev,
   input  logic wr,
   input  logic wd,
   output logic q
);
   logic set_ev, rst_ev;
   assign set_ev = mode && (pol ? own_ev : mst_ev);
   assign rst_ev = mode && (pol ? mst_ev : own_ev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= 1'b0;
      else if (!en) begin
         if (wr)             q <= wd;
      end else if (!mode) begin
         if (own_ev)         q <= ~q;
      end else if (rst_ev)   q <= 1'b0;
      else if (set_ev)       q <= 1'b1;
   end

   a_r1_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      en && !mode && own_ev |=> q != $past(q));
   a_r4_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      en && mode && own_ev && mst_ev |=> !q);
   a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      en && wr && !own_ev && !(mode && mst_ev) |=> $stable(q));
   a_r6_event_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !wr |=> $stable(q));
   a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      !en && wr |=> q == $past(wd));
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl #(
   parameter int          NUM_CH      = 4,
   parameter int          SEL_W       = 2,
   parameter logic [31:0] MASTER_MASK = 32'h5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       ev_i,
   input  logic                    wr_en,
   input  logic [2:0]              wr_sel,
   input  logic [NUM_CH*SEL_W-1:0] wr_data,
   input  logic [NUM_CH-1:0]       wr_mask,
   output logic [NUM_CH-1:0]       lvl_o
);
   localparam int MIN_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_ch
      $error("tmr_out_ctl: NUM_CH must lie in 2..32");
   end
   if (SEL_W < MIN_SEL_W) begin : g_bad_sel
      $error("tmr_out_ctl: SEL_W too narrow to address every channel");
   end

   logic [NUM_CH-1:0]            mode_q, pol_q, en_q, lvl_wr, mst_ev;
   logic [NUM_CH-1:0][SEL_W-1:0] msel_q;

   tmr_out_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .wr_mask(wr_mask), .mode_q(mode_q),
      .pol_q(pol_q), .en_q(en_q), .msel_q(msel_q), .lvl_wr(lvl_wr)
   );

   tmr_out_route #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .MASTER_MASK(MASTER_MASK)) u_route (
      .ev_i(ev_i), .msel_q(msel_q), .mst_ev(mst_ev)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_cell
      tmr_out_cell u_cell (
         .clk(clk), .rst_n(rst_n), .en(en_q[n]), .mode(mode_q[n]),
         .pol(pol_q[n]), .own_ev(ev_i[n]), .mst_ev(mst_ev[n]),
         .wr(lvl_wr[n]), .wd(wr_data[n]), .q(lvl_o[n])
      );
   end

   // R7: channel 0 is never a slave, so no master event may move it while in paired mode
   a_r7_ch0_no_master: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[0] && mode_q[0] && !ev_i[0] |=> $stable(lvl_o[0]));
endmodule

// File: tb/tmr_out_ctl_test.sv
module tmr_out_ctl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0]   ev_i = '0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_sel = '0;
   logic [2*NCH-1:0] wr_data = '0;
   logic [NCH-1:0]   wr_mask = '0;
   logic [NCH-1:0]   lvl_o;

   int n_run = 0, n_fail = 0;
   logic [NCH-1:0] exp_q[$];
   string          tag_q[$];
   bit             done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_out_ctl uut (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .wr_mask(wr_mask), .lvl_o(lvl_o)
   );

   // monitor: compares each expected item at the falling edge after its update edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [NCH-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_run++;
         if (lvl_o !== e) begin
            n_fail++;
            $display("FAIL %s: lvl_o=%b expected %b", t, lvl_o, e);
         end
      end
   end

   // driver: apply one cycle of stimulus, queue the expected latch state
   task automatic step(input logic we, input logic [2:0] sel, input logic [7:0] data,
                       input logic [3:0] mask, input logic [3:0] ev,
                       input logic [3:0] exp, input string tag);
      wr_en = we; wr_sel = sel; wr_data = data; wr_mask = mask; ev_i = ev;
      @(posedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      wr_en = 1'b0; ev_i = '0;
   endtask

   task automatic evt(input logic [3:0] ev, input logic [3:0] exp, input string tag);
      step(1'b0, 3'd0, 8'h00, 4'h0, ev, exp, tag);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            // R9 reset state
            evt(4'b0000, 4'b0000, "R9");
            // R8 enable all channels, single mode
            step(1'b1, 3'd2, 8'h0F, 4'hF, 4'b0000, 4'b0000, "R8");
            evt(4'b0001, 4'b0001, "R1");
            step(1'b1, 3'd1, 8'h0F, 4'hF, 4'b0000, 4'b0001, "R8");
            evt(4'b0001, 4'b0000, "R1");                 // polarity ignored
            evt(4'b1111, 4'b1111, "R1");
            step(1'b1, 3'd3, 8'h00, 4'hF, 4'b0000, 4'b1111, "R5");
            // disable and initialise
            step(1'b1, 3'd2, 8'h00, 4'hF, 4'b0000, 4'b1111, "R8");
            step(1'b1, 3'd3, 8'h00, 4'hF, 4'b0000, 4'b0000, "R6");
            evt(4'b1111, 4'b0000, "R6");
            // paired: ch1,ch2 on master 0, ch3 on master 2
            step(1'b1, 3'd1, 8'h00, 4'hF, 4'b0000, 4'b0000, "R8");
            step(1'b1, 3'd0, 8'h0E, 4'hF, 4'b0000, 4'b0000, "R8");
            step(1'b1, 3'd4, 8'h80, 4'hF, 4'b0000, 4'b0000, "R8");
            step(1'b1, 3'd2, 8'h0F, 4'hF, 4'b0000, 4'b0000, "R8");
            evt(4'b0001, 4'b0111, "R2");
            evt(4'b0100, 4'b1011, "R2");
            evt(4'b1010, 4'b0001, "R2");
            evt(4'b0011, 4'b0100, "R4");
            // polarity 1 on slaves
            step(1'b1, 3'd1, 8'h0E, 4'hF, 4'b0000, 4'b0100, "R8");
            evt(4'b0001, 4'b0001, "R3");
            evt(4'b1010, 4'b1011, "R3");
            evt(4'b0101, 4'b0000, "R4");
            // invalid selections: ch1 -> 2, ch3 -> 1
            step(1'b1, 3'd1, 8'h00, 4'hF, 4'b0000, 4'b0000, "R8");
            step(1'b1, 3'd4, 8'h48, 4'hF, 4'b0000, 4'b0000, "R8");
            evt(4'b0100, 4'b0000, "R7");
            evt(4'b0010, 4'b0000, "R7");
            evt(4'b0001, 4'b0101, "R7");
            // masked enable and latch writes
            step(1'b1, 3'd2, 8'h00, 4'b0001, 4'b0000, 4'b0101, "R8");
            evt(4'b0001, 4'b0101, "R6");
            step(1'b1, 3'd3, 8'h00, 4'hF, 4'b0000, 4'b0100, "R5");
            step(1'b1, 3'd3, 8'h0F, 4'b0001, 4'b0000, 4'b0101, "R6");
            @(negedge clk);
            done = 1;
         end
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               n_run++; n_fail++;
               $display("FAIL watchdog: done=0 expected 1");
            end
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule